// File: doc/BRIEF.md
# Antisymmetric FIR Hilbert Transformer

This block turns a stream of real signed samples into an analytic pair, one sample per clock at most. The imaginary part comes from a 15-tap odd-length FIR with odd symmetry. Its coefficients are zero at the centre and at every even distance from it. For that reason the block first takes the difference of each mirrored sample pair and then spends one multiplier per pair, so four multipliers cover the whole filter. The real part is the centre sample of the same window. It is pushed through matching registers so that both parts leave in the same cycle.

Samples enter with a valid strobe, and the window slides only on accepted samples. A valid bit travels with the data through four register stages: window, pair difference, product and sum. The sum drops the nine fractional bits that the coefficient scaling adds. It then clamps to the output range, which is one bit wider than the input. Typical use is ahead of a magnitude or phase stage in an envelope detector, where the two parts must stay in step.

Top module: `analytic_fir`

## Requirements
- R1: After reset, out_valid is 0 and out_re and out_im are 0 until the first accepted sample has passed through the pipeline.
- R2: A sample presented with in_valid=1 before clock edge k produces out_valid=1 after edge k+3. There is exactly one output per accepted sample and no output for any other cycle.
- R3: out_re equals the sample accepted 7 valid samples before the newest one (the centre of the 15-sample window), sign-extended to DW+1 bits. Window positions not yet filled since reset count as 0.
- R4: With centre c and x[n] the n-th accepted sample, out_im = floor((Σ over j in {1,3,5,7} of (x[c−j] − x[c+j])·W_j) / 512), where W_1=326, W_3=109, W_5=66 and W_7=47.
- R5: The centre sample and samples at even distances from it do not contribute to out_im. A single impulse therefore yields nonzero out_im only when the impulse lies at an odd distance of 1 to 7 from the centre, positive when the impulse is older than the centre and negative when it is newer.
- R6: When the R4 value exceeds the DW+1-bit signed range, out_im saturates to +(2^DW − 1) or −2^DW.
- R7: A cycle with in_valid=0 neither shifts the window nor changes the result of any later sample. While out_valid is 0, out_re and out_im keep their last values.
- R8: For a cosine input of amplitude 1500 and period 10.3 samples, once the window holds only cosine samples, out_im stays within 30 LSB of 1500·sin at the centre sample's phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_sample holds a new sample this cycle |
| in_sample | input | DW | Signed two's-complement input sample |
| out_valid | output | 1 | out_re and out_im carry a new result |
| out_re | output | DW+1 | Real part: the delayed centre sample, sign-extended |
| out_im | output | DW+1 | Imaginary part: the filtered, scaled and saturated sum |

## Verification
The bench uses five kinds of input. A single impulse shows each coefficient separately, together with its sign and its distance from the centre, and shows that even distances add nothing. A pseudo-random full-range sequence tests the pair subtraction, the truncation toward minus infinity and the alignment of the real part against an exact integer model. Full-scale steps in both directions force the sum past the output range, which separates correct clamping from wrap-around. A stream with gaps and a long idle stretch shows that idle cycles neither shift the window nor disturb the held outputs. A sampled cosine tests the quadrature behaviour against a sine within a fixed error bound.

// File: rtl/analytic_fir_pkg.sv
package analytic_fir_pkg;

    localparam int unsigned COEF_W_DEF = 10;
    localparam int unsigned FRAC_DEF   = 9;

    // Magnitude of the coefficient at odd distance off from the centre,
    // scaled by 2^FRAC_DEF. Distances beyond 7 use a rounded integer
    // approximation of 1024/(off*pi).
    function automatic int tap_weight(input int off);
        case (off)
            1:       return 326;
            3:       return 109;
            5:       return 66;
            7:       return 47;
            default: return (2048000 / (off * 3141) + 1) / 2;
        endcase
    endfunction

endpackage

// File: rtl/analytic_fir_tapline.sv
module analytic_fir_tapline #(
    parameter int unsigned DW   = 12,
    parameter int unsigned TAPS = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [DW-1:0]                 din,
    output logic [TAPS-1:0][DW-1:0]       taps_o,
    output logic                          vld_o
);

    typedef struct packed {
        logic [TAPS-1:0][DW-1:0] tap;
        logic                    vld;
    } tl_state_t;

    tl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = shift_en;
        if (shift_en) begin
            st_d.tap[0] = din;
            for (int i = 1; i < int'(TAPS); i++) begin
                st_d.tap[i] = st_q.tap[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps_o = st_q.tap;
    assign vld_o  = st_q.vld;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(st_q.tap));

endmodule

// File: rtl/analytic_fir_presub.sv
module analytic_fir_presub #(
    parameter int unsigned DW    = 12,
    parameter int unsigned HALF  = 7,
    localparam int unsigned TAPS  = 2 * HALF + 1,
    localparam int unsigned NPAIR = (HALF + 1) / 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TAPS-1:0][DW-1:0]       taps_i,
    input  logic                          vld_i,
    output logic [NPAIR-1:0][DW:0]        diff_o,
    output logic [DW-1:0]                 centre_o,
    output logic                          vld_o
);

    typedef struct packed {
        logic [NPAIR-1:0][DW:0] diff;
        logic [DW-1:0]          centre;
        logic                   vld;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [NPAIR-1:0][DW:0] pair_w;

    // Older sample (higher index) minus the newer mirror sample.
    for (genvar p = 0; p < int'(NPAIR); p++) begin : g_pair
        localparam int unsigned OFF = 2 * p + 1;
        logic signed [DW:0] older_x, newer_x;
        assign older_x   = {taps_i[HALF+OFF][DW-1], taps_i[HALF+OFF]};
        assign newer_x   = {taps_i[HALF-OFF][DW-1], taps_i[HALF-OFF]};
        assign pair_w[p] = older_x - newer_x;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.diff   = pair_w;
            st_d.centre = taps_i[HALF];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign diff_o   = st_q.diff;
    assign centre_o = st_q.centre;
    assign vld_o    = st_q.vld;

endmodule

// File: rtl/analytic_fir_mac.sv
module analytic_fir_mac
    import analytic_fir_pkg::*;
#(
    parameter int unsigned DW     = 12,
    parameter int unsigned NPAIR  = 4,
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned FRAC   = FRAC_DEF,
    localparam int unsigned OW    = DW + 1,
    localparam int unsigned PW    = DW + 1 + COEF_W,
    localparam int unsigned SW    = PW + $clog2(NPAIR) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPAIR-1:0][DW:0]   diff_i,
    input  logic [DW-1:0]            centre_i,
    input  logic                     vld_i,
    output logic                     out_valid,
    output logic [OW-1:0]            out_re,
    output logic [OW-1:0]            out_im
);

    localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< (OW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] MINV = -(SW'(1) <<< (OW - 1));

    typedef struct packed {
        logic [NPAIR-1:0][PW-1:0] prod;
        logic [DW-1:0]            centre;
        logic                     vld_m;
        logic [OW-1:0]            re;
        logic [OW-1:0]            im;
        logic                     vld_o;
    } mac_state_t;

    mac_state_t st_d, st_q;
    logic [NPAIR-1:0][PW-1:0] prod_w;
    logic signed [SW-1:0]     acc_w, scaled_w;

    for (genvar p = 0; p < int'(NPAIR); p++) begin : g_mul
        localparam logic signed [PW-1:0] WK = PW'(tap_weight(2 * p + 1));
        logic signed [DW:0]   dd;
        logic signed [PW-1:0] dext;
        assign dd        = diff_i[p];
        assign dext      = PW'(dd);
        assign prod_w[p] = dext * WK;
    end

    always_comb begin
        acc_w = '0;
        for (int p = 0; p < int'(NPAIR); p++) begin
            acc_w = acc_w + SW'($signed(st_q.prod[p]));
        end
        scaled_w = acc_w >>> FRAC;
    end

    always_comb begin
        st_d       = st_q;
        st_d.vld_m = vld_i;
        st_d.vld_o = st_q.vld_m;
        if (vld_i) begin
            st_d.prod   = prod_w;
            st_d.centre = centre_i;
        end
        if (st_q.vld_m) begin
            st_d.re = OW'($signed(st_q.centre));
            if (scaled_w > MAXV)      st_d.im = OW'(MAXV);
            else if (scaled_w < MINV) st_d.im = OW'(MINV);
            else                      st_d.im = OW'(scaled_w);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld_o;
    assign out_re    = st_q.re;
    assign out_im    = st_q.im;

    // R5
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && diff_i == '0) |=> (st_q.prod == '0));

    // R4
    zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld_m && st_q.prod == '0) |=> (st_q.im == '0));

endmodule

// File: rtl/analytic_fir.sv
module analytic_fir
    import analytic_fir_pkg::*;
#(
    parameter int unsigned DW     = 12,
    parameter int unsigned HALF   = 7,
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned FRAC   = FRAC_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_sample,
    output logic          out_valid,
    output logic [DW:0]   out_re,
    output logic [DW:0]   out_im
);

    localparam int unsigned TAPS  = 2 * HALF + 1;
    localparam int unsigned NPAIR = (HALF + 1) / 2;

    logic [TAPS-1:0][DW-1:0] taps_w;
    logic                    win_vld;
    logic [NPAIR-1:0][DW:0]  diff_w;
    logic [DW-1:0]           centre_w;
    logic                    sub_vld;

    analytic_fir_tapline #(.DW(DW), .TAPS(TAPS)) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_sample),
        .taps_o   (taps_w),
        .vld_o    (win_vld)
    );

    analytic_fir_presub #(.DW(DW), .HALF(HALF)) u_presub (
        .clk      (clk),
        .rst_n    (rst_n),
        .taps_i   (taps_w),
        .vld_i    (win_vld),
        .diff_o   (diff_w),
        .centre_o (centre_w),
        .vld_o    (sub_vld)
    );

    analytic_fir_mac #(.DW(DW), .NPAIR(NPAIR), .COEF_W(COEF_W), .FRAC(FRAC)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .diff_i    (diff_w),
        .centre_i  (centre_w),
        .vld_i     (sub_vld),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));

endmodule

// File: tb/analytic_fir_tb.sv
`timescale 1ns/1ps
module analytic_fir_tb;

    localparam int DW   = 12;
    localparam int OMAX = 4095;
    localparam int OMIN = -4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          out_valid;
    logic [DW:0]   out_re, out_im;

    always #4 clk = ~clk;

    analytic_fir u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    mon_on = 1'b0, done = 1'b0;
    string imtag = "R4";
    int    h[$];
    int    q_re[$], q_im[$], q_cyc[$];
    bit    q_cos[$];
    real   q_sin[$];
    string q_tag[$];
    int    last_re = 0, last_im = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int hget(int n);
        if (n < 0 || n >= h.size()) return 0;
        return h[n];
    endfunction

    function automatic int wt(int j);
        case (j) 1: return 326; 3: return 109; 5: return 66; default: return 47; endcase
    endfunction

    task automatic feed(int v, bit vld, bit cos_on = 1'b0, real sinexp = 0.0);
        @(negedge clk);
        in_valid  = vld;
        in_sample = v[DW-1:0];
        if (vld) begin
            int k, c, acc, im;
            h.push_back(v);
            k = h.size() - 1;
            c = k - 7;
            acc = 0;
            for (int p = 0; p < 4; p++) begin
                int j = 2 * p + 1;
                acc += (hget(c - j) - hget(c + j)) * wt(j);
            end
            im = acc >>> 9;
            if (im > OMAX) im = OMAX;
            if (im < OMIN) im = OMIN;
            q_re.push_back(hget(c));
            q_im.push_back(im);
            q_cyc.push_back(cyc + 4);
            q_cos.push_back(cos_on);
            q_sin.push_back(sinexp);
            q_tag.push_back(imtag);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 50 && q_re.size() != 0; i++) @(negedge clk);
        chk(q_re.size() == 0, "R2", "pending outputs", q_re.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            int are, aim;
            are = int'($signed(out_re));
            aim = int'($signed(out_im));
            if (out_valid) begin
                if (q_re.size() == 0) begin
                    chk(1'b0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    int er, ei, ec;
                    bit cz;
                    real se;
                    string tg;
                    er = q_re.pop_front(); ei = q_im.pop_front(); ec = q_cyc.pop_front();
                    cz = q_cos.pop_front(); se = q_sin.pop_front(); tg = q_tag.pop_front();
                    chk(cyc == ec, "R2", "output cycle", cyc, ec);
                    chk(are == er, "R3", "out_re", are, er);
                    chk(aim == ei, tg, "out_im", aim, ei);
                    if (cz) begin
                        real d;
                        d = real'(aim) - se;
                        if (d < 0.0) d = -d;
                        chk(d <= 30.0, "R8", "out_im vs sine", aim, $rtoi(se));
                    end
                end
                last_re = are;
                last_im = aim;
            end else begin
                chk(are == last_re && aim == last_im, "R7", "hold while idle",
                    aim, last_im);
            end
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
            chk(out_re == '0 && out_im == '0, "R1", "outputs after reset",
                int'($signed(out_im)), 0);
        end
        mon_on = 1'b1;
    endtask

    task automatic t_impulse();
        imtag = "R5";
        feed(1000, 1'b1);
        for (int i = 0; i < 20; i++) feed(0, 1'b1);
        drain();
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        imtag = "R4";
        for (int i = 0; i < 64; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            feed(int'($signed(lf[11:0])), 1'b1);
        end
        drain();
    endtask

    task automatic t_saturate();
        imtag = "R6";
        for (int i = 0; i < 8; i++) feed(2047, 1'b1);
        for (int i = 0; i < 8; i++) feed(-2048, 1'b1);
        for (int i = 0; i < 8; i++) feed(2047, 1'b1);
        for (int i = 0; i < 8; i++) feed(0, 1'b1);
        drain();
    endtask

    task automatic t_gaps();
        logic [15:0] lf = 16'h1D0F;
        imtag = "R7";
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            feed(int'($signed(lf[11:0])), (i % 3) != 2);
            if (i == 20) for (int g = 0; g < 5; g++) feed(1234, 1'b0);
        end
        drain();
    endtask

    task automatic t_cosine();
        real w;
        w = 2.0 * 3.14159265358979 / 10.3;
        imtag = "R4";
        for (int i = 0; i < 100; i++) begin
            real cv;
            int  v;
            cv = 1500.0 * $cos(w * i);
            v  = (cv >= 0.0) ? $rtoi(cv + 0.5) : $rtoi(cv - 0.5);
            feed(v, 1'b1, (i >= 14), 1500.0 * $sin(w * (i - 7)));
        end
        drain();
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_random();
        t_saturate();
        t_gaps();
        t_cosine();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule